// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Lockout

This block recovers characters from an asynchronous serial line. The line goes through a two-stage synchroniser. The receiver then waits for a low level on the line and checks that level again at the middle of the start bit. After that it samples each data bit at its centre, using a strobe that runs at sixteen times the bit rate. Data arrives least significant bit first. An optional parity bit follows the data, then one or two stop bits. When a character is complete, the block judges it and either copies it into a holding register or leaves that register alone. It then updates a full flag and three error flags: overrun, framing and parity.

Each error type handles the data in its own way. A character with a parity or framing error is still copied into the holding register. A character that overruns an unread one is dropped. An error flag that is set stops the receiver from taking in any further character until software clears it. Software clears each flag with a single-cycle strobe. Two level interrupt outputs, gated by one enable, report data ready and error.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, rxData is 0, and every flag and both interrupt outputs are 0.
- R2: A low line level is treated as a start bit only if it is still low at the mid-bit sample. The mid-bit sample is the eighth sampleTick after detection. A shorter low pulse is ignored and no character results. One bit lasts 16 sampleTick strobes.
- R3: Data bits are taken least significant bit first. cfgLongChar=1 selects 8 data bits and cfgLongChar=0 selects 7. A 7-bit character lands in rxData[6:0] with rxData[7] at 0.
- R4: With cfgParityEn=1, one parity bit follows the data. cfgParityOdd=0 requires an even count of ones over the data and parity bits together, and cfgParityOdd=1 requires an odd count. On a mismatch, parityFlag is set and the data is still stored.
- R5: Only the first stop bit is checked. A 0 there sets framingFlag and the data is still stored. With cfgTwoStop=1, the value of the second stop bit has no effect.
- R6: If a character completes while fullFlag is 1, overrunFlag is set and rxData keeps its previous value.
- R7: A character with no error sets fullFlag and is stored. On any error, fullFlag keeps the value it had before the character.
- R8: While overrunFlag, framingFlag or parityFlag is 1, incoming characters are ignored: rxData and all flags stay unchanged. Once the error flags are cleared, reception resumes.
- R9: clrFull, clrOverrun, clrFraming and clrParity each clear only their own flag. A set in the same cycle as a clear wins.
- R10: rxIrq equals rxIntEn AND fullFlag. errIrq equals rxIntEn AND (any error flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversampling strobe, 16 per bit |
| rxLine | input | 1 | Serial input, idle high |
| cfgLongChar | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParityEn | input | 1 | Parity bit present and checked |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgTwoStop | input | 1 | Two stop bits per frame |
| rxIntEn | input | 1 | Interrupt enable |
| clrFull | input | 1 | Clear strobe for fullFlag |
| clrOverrun | input | 1 | Clear strobe for overrunFlag |
| clrFraming | input | 1 | Clear strobe for framingFlag |
| clrParity | input | 1 | Clear strobe for parityFlag |
| rxData | output | 8 | Holding register |
| fullFlag | output | 1 | Holding register contains unread data |
| overrunFlag | output | 1 | A character was lost to an overrun |
| framingFlag | output | 1 | First stop bit was 0 |
| parityFlag | output | 1 | Parity mismatch |
| rxIrq | output | 1 | Data-ready interrupt |
| errIrq | output | 1 | Error interrupt |

## Verification
On every cycle the assertions check the following. The holding register changes only when a character is accepted, and never in the cycle an overrun is flagged. fullFlag never rises together with an error flag. Nothing changes while the receiver is locked out. A flag falls only after its clear strobe. The interrupt outputs stay quiet while disabled. The bench scenarios are needed for the rest: the bit order, the parity polarity, which stop bit is checked, noise rejection on the start bit, and the set-over-clear race. Each of these depends on a whole serial frame driven at the line.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef struct packed {
    logic shiftBit;   // sample a data bit into the shift register
    logic capParity;  // sample the parity bit
    logic endFrame;   // sample the first stop bit and judge the character
  } rxStrobe_t;
endpackage

// File: rtl/rx_control.sv
module rx_control
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       lineS,
  input  logic       lockout,
  input  logic       cfgLongChar,
  input  logic       cfgParityEn,
  input  logic       cfgTwoStop,
  output rxStrobe_t  strobe
);
  localparam int PHASE_W    = $clog2(OVERSAMPLE);
  localparam int IDX_W      = $clog2(DATA_MAX);
  localparam int MID_PHASE  = OVERSAMPLE / 2 - 1;
  localparam int LAST_PHASE = OVERSAMPLE - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2
  } rxState_t;

  rxState_t            state, stateNext;
  logic [PHASE_W-1:0]  phase, phaseNext;
  logic [IDX_W-1:0]    bitIdx, idxNext;
  logic [IDX_W-1:0]    lastIdx;
  logic                phaseEnd;

  assign lastIdx  = cfgLongChar ? IDX_W'(DATA_MAX - 1) : IDX_W'(DATA_MAX - 2);
  assign phaseEnd = sampleTick && (phase == PHASE_W'(LAST_PHASE));

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    idxNext   = bitIdx;
    if (state != S_IDLE && state != S_START && sampleTick)
      phaseNext = phaseEnd ? '0 : phase + 1'b1;
    case (state)
      S_IDLE: begin
        if (sampleTick && !lineS && !lockout) begin
          stateNext = S_START;
          phaseNext = '0;
        end
      end
      S_START: begin
        if (sampleTick) begin
          if (phase == PHASE_W'(MID_PHASE)) begin
            phaseNext = '0;
            idxNext   = '0;
            stateNext = lineS ? S_IDLE : S_DATA;
          end else begin
            phaseNext = phase + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (phaseEnd) begin
          idxNext = bitIdx + 1'b1;
          if (bitIdx == lastIdx) stateNext = cfgParityEn ? S_PAR : S_STOP;
        end
      end
      S_PAR:   if (phaseEnd) stateNext = S_STOP;
      S_STOP:  if (phaseEnd) stateNext = cfgTwoStop ? S_STOP2 : S_IDLE;
      S_STOP2: if (phaseEnd) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      phase  <= phaseNext;
      bitIdx <= idxNext;
    end
  end

  always_comb begin
    strobe.shiftBit  = phaseEnd && (state == S_DATA);
    strobe.capParity = phaseEnd && (state == S_PAR);
    strobe.endFrame  = phaseEnd && (state == S_STOP);
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int DATA_MAX = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobe_t           strobe,
  input  logic                cfgLongChar,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic                rxIntEn,
  input  logic                clrFull,
  input  logic                clrOverrun,
  input  logic                clrFraming,
  input  logic                clrParity,
  output logic                lineS,
  output logic                lockout,
  output logic [DATA_MAX-1:0] rxData,
  output logic                fullFlag,
  output logic                overrunFlag,
  output logic                framingFlag,
  output logic                parityFlag,
  output logic                rxIrq,
  output logic                errIrq
);
  logic [SYNC_LEN-1:0] syncQ;
  logic [DATA_MAX-1:0] shiftQ;
  logic [DATA_MAX-1:0] charWord;
  logic                parBit;
  logic                badParity, badStop, lost, clean;

  // Synchroniser: idle-high line, so it resets to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_LEN-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_LEN-1];

  // Shift register: new bits enter at the top, so the first bit ends lowest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parBit <= 1'b0;
    end else begin
      if (strobe.shiftBit)  shiftQ <= {lineS, shiftQ[DATA_MAX-1:1]};
      if (strobe.capParity) parBit <= lineS;
    end
  end

  assign charWord  = cfgLongChar ? shiftQ : {1'b0, shiftQ[DATA_MAX-1:1]};
  assign badParity = cfgParityEn && ((^charWord ^ parBit) != cfgParityOdd);
  assign badStop   = !lineS;
  assign lost      = fullFlag;
  assign clean     = !badParity && !badStop && !lost;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      fullFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      framingFlag <= 1'b0;
      parityFlag  <= 1'b0;
    end else begin
      if (strobe.endFrame && !lost) rxData <= charWord;
      fullFlag    <= (strobe.endFrame && clean)     || (fullFlag    && !clrFull);
      overrunFlag <= (strobe.endFrame && lost)      || (overrunFlag && !clrOverrun);
      framingFlag <= (strobe.endFrame && badStop)   || (framingFlag && !clrFraming);
      parityFlag  <= (strobe.endFrame && badParity) || (parityFlag  && !clrParity);
    end
  end

  assign lockout = overrunFlag || framingFlag || parityFlag;
  assign rxIrq   = rxIntEn && fullFlag;
  assign errIrq  = rxIntEn && lockout;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import rx_pkg::*;
#(
  parameter int DATA_MAX   = 8,
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_LEN   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                rxLine,
  input  logic                cfgLongChar,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic                cfgTwoStop,
  input  logic                rxIntEn,
  input  logic                clrFull,
  input  logic                clrOverrun,
  input  logic                clrFraming,
  input  logic                clrParity,
  output logic [DATA_MAX-1:0] rxData,
  output logic                fullFlag,
  output logic                overrunFlag,
  output logic                framingFlag,
  output logic                parityFlag,
  output logic                rxIrq,
  output logic                errIrq
);
  rxStrobe_t strobe;
  logic      lineS;
  logic      lockout;

  rx_control #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineS(lineS),
    .lockout(lockout), .cfgLongChar(cfgLongChar), .cfgParityEn(cfgParityEn),
    .cfgTwoStop(cfgTwoStop), .strobe(strobe)
  );

  rx_datapath #(.DATA_MAX(DATA_MAX), .SYNC_LEN(SYNC_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobe(strobe),
    .cfgLongChar(cfgLongChar), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .rxIntEn(rxIntEn),
    .clrFull(clrFull), .clrOverrun(clrOverrun), .clrFraming(clrFraming),
    .clrParity(clrParity), .lineS(lineS), .lockout(lockout),
    .rxData(rxData), .fullFlag(fullFlag), .overrunFlag(overrunFlag),
    .framingFlag(framingFlag), .parityFlag(parityFlag),
    .rxIrq(rxIrq), .errIrq(errIrq)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DATA_MAX = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgLongChar,
  input logic                rxIntEn,
  input logic                clrFull,
  input logic                clrOverrun,
  input logic                clrFraming,
  input logic                clrParity,
  input logic [DATA_MAX-1:0] rxData,
  input logic                fullFlag,
  input logic                overrunFlag,
  input logic                framingFlag,
  input logic                parityFlag,
  input logic                rxIrq,
  input logic                errIrq
);
  logic anyErr;
  assign anyErr = overrunFlag || framingFlag || parityFlag;

  a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $stable(rxData));

  a_r7_full_only_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> !$rose(overrunFlag) && !$rose(framingFlag) && !$rose(parityFlag));

  a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> $stable(rxData) && !$rose(fullFlag));

  a_r3_short_char_msb: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(fullFlag) && !cfgLongChar) |-> !rxData[DATA_MAX-1]);

  a_r9_full_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullFlag) |-> $past(clrFull));

  a_r9_err_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(overrunFlag) |-> $past(clrOverrun)) and
    ($fell(framingFlag) |-> $past(clrFraming)) and
    ($fell(parityFlag)  |-> $past(clrParity)));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEn |-> !rxIrq && !errIrq);

  a_r10_irq_sources: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq |-> fullFlag) and (errIrq |-> anyErr));
endmodule

bind serial_rx_unit serial_rx_checker #(.DATA_MAX(DATA_MAX)) u_chk (.*);

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       cfgLongChar = 1'b1, cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic       rxIntEn = 1'b1;
  logic       clrFull = 1'b0, clrOverrun = 1'b0, clrFraming = 1'b0, clrParity = 1'b0;
  logic [7:0] rxData;
  logic       fullFlag, overrunFlag, framingFlag, parityFlag, rxIrq, errIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  serial_rx_unit u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgLongChar(cfgLongChar), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop), .rxIntEn(rxIntEn),
    .clrFull(clrFull), .clrOverrun(clrOverrun), .clrFraming(clrFraming),
    .clrParity(clrParity), .rxData(rxData), .fullFlag(fullFlag),
    .overrunFlag(overrunFlag), .framingFlag(framingFlag),
    .parityFlag(parityFlag), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  typedef struct packed {
    logic       longChar, parEn, parOdd, twoStop, badPar, stop1, stop2;
    logic [7:0] data;
    logic [7:0] expData;
    logic       expFull, expFer, expPer;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'hA5, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'h55, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h81, 8'h81, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h5A, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F, 8'h0F, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h7F, 8'h7F, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h7F, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    repeat (16) @(negedge clk);
  endtask

  // start, data LSB first, optional parity, stop bits, then idle
  task automatic sendFrame(input logic [7:0] d, input logic longC, input logic pEn,
                           input logic pOdd, input logic two, input logic badP,
                           input logic s1, input logic s2);
    logic [7:0] used;
    used = longC ? d : (d & 8'h7F);
    cfgLongChar = longC; cfgParityEn = pEn; cfgParityOdd = pOdd; cfgTwoStop = two;
    sendBit(1'b0);
    for (int i = 0; i < (longC ? 8 : 7); i++) sendBit(d[i]);
    if (pEn) sendBit((^used) ^ pOdd ^ badP);
    sendBit(s1);
    if (two) sendBit(s2);
    rxLine = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic clearAll();
    clrFull = 1'b1; clrOverrun = 1'b1; clrFraming = 1'b1; clrParity = 1'b1;
    @(negedge clk);
    clrFull = 1'b0; clrOverrun = 1'b0; clrFraming = 1'b0; clrParity = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seenFull;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 data", rxData, 8'h00);
    chk("R1 flags", {4'b0, fullFlag, overrunFlag, framingFlag, parityFlag}, 8'h00);
    chk("R1 irqs", {6'b0, rxIrq, errIrq}, 8'h00);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: formats, parity, stop-bit handling
    for (int v = 0; v < NVEC; v++) begin
      sendFrame(VECS[v].data, VECS[v].longChar, VECS[v].parEn, VECS[v].parOdd,
                VECS[v].twoStop, VECS[v].badPar, VECS[v].stop1, VECS[v].stop2);
      chk("R3 data", rxData, VECS[v].expData);
      chk("R7 full", {7'b0, fullFlag}, {7'b0, VECS[v].expFull});
      chk("R5 framing", {7'b0, framingFlag}, {7'b0, VECS[v].expFer});
      chk("R4 parity", {7'b0, parityFlag}, {7'b0, VECS[v].expPer});
      chk("R10 rxIrq", {7'b0, rxIrq}, {7'b0, VECS[v].expFull});
      clearAll();
    end

    // R6: overrun drops the second character
    sendFrame(8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    sendFrame(8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 overrun flag", {7'b0, overrunFlag}, 8'h01);
    chk("R6 data kept", rxData, 8'h11);
    chk("R7 full kept", {7'b0, fullFlag}, 8'h01);
    chk("R10 errIrq", {7'b0, errIrq}, 8'h01);

    // R8: locked out while an error flag is set
    sendFrame(8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 data frozen", rxData, 8'h11);
    chk("R8 no framing", {7'b0, framingFlag}, 8'h00);

    // R9: a clear strobe touches only its own flag
    clrFull = 1'b1; @(negedge clk); clrFull = 1'b0; @(negedge clk);
    chk("R9 full cleared", {7'b0, fullFlag}, 8'h00);
    chk("R9 overrun held", {7'b0, overrunFlag}, 8'h01);
    clrOverrun = 1'b1; @(negedge clk); clrOverrun = 1'b0; @(negedge clk);
    chk("R9 overrun cleared", {7'b0, overrunFlag}, 8'h00);

    // R8: reception resumes after clearing
    sendFrame(8'h44, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 resumed", rxData, 8'h44);

    // R10: interrupt gating
    rxIntEn = 1'b0; @(negedge clk);
    chk("R10 rxIrq masked", {7'b0, rxIrq}, 8'h00);
    rxIntEn = 1'b1; @(negedge clk);
    chk("R10 rxIrq enabled", {7'b0, rxIrq}, 8'h01);
    clearAll();

    // R2: short low glitch is rejected, then a real frame is aligned correctly
    rxLine = 1'b0; repeat (4) @(negedge clk);
    rxLine = 1'b1; repeat (40) @(negedge clk);
    chk("R2 glitch ignored", {7'b0, fullFlag}, 8'h00);
    sendFrame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R2 frame after glitch", rxData, 8'hC3);
    chk("R2 no error after glitch", {7'b0, framingFlag}, 8'h00);
    clearAll();

    // R9: set wins over a clear held through the whole frame
    seenFull = 1'b0;
    clrFull = 1'b1;
    fork
      sendFrame(8'h96, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      repeat (200) begin
        @(negedge clk);
        if (fullFlag) seenFull = 1'b1;
      end
    join
    clrFull = 1'b0;
    chk("R9 set beats clear", {7'b0, seenFull}, 8'h01);
    chk("R9 data with held clear", rxData, 8'h96);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule